// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer

The block is a 16-bit timer with eight channels. One free-running counter advances on every clock while the run enable is set. Each channel owns a 16-bit register. A per-channel mode bit decides how that register is used. In capture mode, the register samples the counter when a chosen edge arrives on the channel's input pin. In compare mode, the register holds a target value, and the channel emits a one-cycle match pulse when the counter steps onto that value. Capture and match events set sticky per-channel flags. A counter wrap from 0xFFFF to 0x0000 sets an overflow flag.

Software reaches the block over an 8-bit byte bus. Every 16-bit quantity takes two addresses, with the high byte at the even address. Reading a high byte freezes the matching low byte in a holding latch, so a pair of accesses taken high first returns one coherent value. Writing a high byte parks it in a buffer, and the full register changes only on the low-byte write that follows. All flags clear by writing ones to them, and a clear takes effect only while the run enable or the accumulate enable is set.

Top module: `capcmp_timer`

## Requirements
- R1: The counter resets to 0 and advances by one on each clock edge while the run enable (bit 0 of address 0x00) is 1. It holds while that bit is 0. Reading address 0x06 then 0x07 returns the counter.
- R2: The overflow flag (output `ovfFlag`, also bit 7 of address 0x05) sets on the edge where a running counter goes from 0xFFFF to 0x0000.
- R3: Writing a byte with bit 7 set to address 0x05 clears the overflow flag only while the run enable or the accumulate enable (bit 1 of address 0x00) is 1. Otherwise the write is ignored, and writing with bit 7 clear never clears the flag.
- R4: Bit i of address 0x01 selects channel i's mode: 0 is capture, 1 is compare.
- R5: In capture mode, channel i uses the 2-bit code in bits [2(i mod 4)+1 : 2(i mod 4)] of address 0x02 (channels 0-3) or 0x03 (channels 4-7): 00 none, 01 rising, 10 falling, 11 both edges. The input passes through two flops. On the third clock edge after an input change, the channel register takes the counter value and the channel flag sets.
- R6: In compare mode, on the edge where a running counter steps to a value equal to channel i's register, `matchPulse[i]` goes high for one cycle and channel i's flag sets.
- R7: Channel flags (output `chanFlag`, also address 0x04) clear per bit when a one is written to address 0x04, only while the run or accumulate enable is 1. A set event wins over a clear in the same cycle.
- R8: All channel registers reset to 0x0000. Register writes take effect in compare mode and are ignored in capture mode.
- R9: Channel i's register sits at addresses 0x10+2i (high byte) and 0x11+2i (low byte).
- R10: Reading a high byte (a channel's or 0x06) copies the matching low byte into a single holding latch. A low-byte read returns that latch, not the live value.
- R11: Writing a channel's high byte only loads a buffer. The channel register changes on the next low-byte write, to {buffer, low byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address |
| busWe | input | 1 | Byte write strobe |
| busRe | input | 1 | Byte read strobe (moves the holding latch) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| capIn | input | 8 | Per-channel capture inputs, asynchronous |
| matchPulse | output | 8 | One-cycle compare match per channel |
| chanFlag | output | 8 | Sticky per-channel event flags |
| ovfFlag | output | 1 | Sticky counter overflow flag |

## Verification
The overflow corner is the hardest case to reach from the ports. The counter cannot be loaded, so it must run through 65,536 steps to reach a wrap at a predictable cycle. The stimulus reads the halted counter, enables it, and waits exactly the remaining count, checking the flag one cycle before and on the wrap edge. Capture values are made predictable by halting the counter before each input edge. The match sweep gives the eight channels targets one count apart, so each cycle has exactly one expected pulse.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CH_NUM = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam int EDGE_W = 2;
  localparam int IDX_W  = $clog2(CH_NUM);

  typedef struct packed {
    logic                       tmrEn;
    logic                       accEn;
    logic [CH_NUM-1:0]          modeSel;
    logic [CH_NUM*EDGE_W-1:0]   edgeSel;
    logic [CH_NUM-1:0]          chanWr;
    logic [CNT_W-1:0]           wrData;
    logic [CH_NUM-1:0]          flagClr;
    logic                       ovfClr;
  } dpCtrl_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWe,
  input  logic                    busRe,
  input  logic [BYTE_W-1:0]       busWdata,
  output logic [BYTE_W-1:0]       busRdata,
  input  logic [CNT_W-1:0]        cntVal,
  input  logic [CH_NUM*CNT_W-1:0] chanVals,
  input  logic [CH_NUM-1:0]       chanFlags,
  input  logic                    ovfFlag,
  output dpCtrl_t                 dpCtl
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EDGE0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EDGE1 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OVF   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CNTH  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CNTL  = ADDR_W'(7);
  localparam int CH_BASE = 16;
  localparam int OVF_BIT = 7;
  localparam int EDGE_HALF = CH_NUM * EDGE_W / 2;

  logic [1:0]                ctrlQ;
  logic [CH_NUM-1:0]         modeQ;
  logic [CH_NUM*EDGE_W-1:0]  edgeQ;
  logic [BYTE_W-1:0]         hiBuf;
  logic [BYTE_W-1:0]         rdLatch;

  logic [ADDR_W-1:0]  chOff;
  logic [IDX_W-1:0]   chIdx;
  logic               isChan;
  logic               isLow;
  logic               clrGate;
  logic [CNT_W-1:0]   chanSel;

  assign chOff   = busAddr - ADDR_W'(CH_BASE);
  assign chIdx   = chOff[IDX_W:1];
  assign isChan  = (int'(busAddr) >= CH_BASE) && (int'(busAddr) < CH_BASE + 2*CH_NUM);
  assign isLow   = busAddr[0];
  assign clrGate = ctrlQ[0] | ctrlQ[1];
  assign chanSel = chanVals[chIdx*CNT_W +: CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      modeQ <= '0;
      edgeQ <= '0;
      hiBuf <= '0;
    end else if (busWe) begin
      if (busAddr == A_CTRL)       ctrlQ <= busWdata[1:0];
      else if (busAddr == A_MODE)  modeQ <= CH_NUM'(busWdata);
      else if (busAddr == A_EDGE0) edgeQ[EDGE_HALF-1:0] <= EDGE_HALF'(busWdata);
      else if (busAddr == A_EDGE1) edgeQ[2*EDGE_HALF-1:EDGE_HALF] <= EDGE_HALF'(busWdata);
      else if (isChan && !isLow)   hiBuf <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLatch <= '0;
    end else if (busRe) begin
      if (busAddr == A_CNTH)     rdLatch <= cntVal[BYTE_W-1:0];
      else if (isChan && !isLow) rdLatch <= chanSel[BYTE_W-1:0];
    end
  end

  always_comb begin
    dpCtl.tmrEn   = ctrlQ[0];
    dpCtl.accEn   = ctrlQ[1];
    dpCtl.modeSel = modeQ;
    dpCtl.edgeSel = edgeQ;
    dpCtl.wrData  = {hiBuf, busWdata};
    dpCtl.chanWr  = (busWe && isChan && isLow) ? (CH_NUM'(1) << chIdx) : '0;
    dpCtl.flagClr = (busWe && busAddr == A_FLAG && clrGate) ? CH_NUM'(busWdata) : '0;
    dpCtl.ovfClr  = busWe && (busAddr == A_OVF) && clrGate && busWdata[OVF_BIT];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL:  busRdata = BYTE_W'(ctrlQ);
      A_MODE:  busRdata = BYTE_W'(modeQ);
      A_EDGE0: busRdata = BYTE_W'(edgeQ[EDGE_HALF-1:0]);
      A_EDGE1: busRdata = BYTE_W'(edgeQ[2*EDGE_HALF-1:EDGE_HALF]);
      A_FLAG:  busRdata = BYTE_W'(chanFlags);
      A_OVF:   busRdata = BYTE_W'(ovfFlag) << OVF_BIT;
      A_CNTH:  busRdata = cntVal[CNT_W-1:BYTE_W];
      A_CNTL:  busRdata = rdLatch;
      default: begin
        if (isChan) busRdata = isLow ? rdLatch : chanSel[CNT_W-1:BYTE_W];
      end
    endcase
  end
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CH_NUM-1:0]       capIn,
  input  dpCtrl_t                 dpCtl,
  output logic [CNT_W-1:0]        cntVal,
  output logic [CH_NUM*CNT_W-1:0] chanVals,
  output logic [CH_NUM-1:0]       chanFlags,
  output logic                    ovfFlag,
  output logic [CH_NUM-1:0]       matchPulse
);
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntNext;
  logic              ovfQ;
  logic [CH_NUM-1:0] syncA, syncB, syncC;
  logic [CH_NUM-1:0] riseHit, fallHit;

  assign cntNext = cntQ + CNT_W'(1);
  assign cntVal  = cntQ;
  assign ovfFlag = ovfQ;
  assign riseHit = syncB & ~syncC;
  assign fallHit = ~syncB & syncC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (dpCtl.tmrEn) cntQ <= cntNext;
      if (dpCtl.tmrEn && (cntQ == '1)) ovfQ <= 1'b1;
      else if (dpCtl.ovfClr)           ovfQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : gChan
    logic [EDGE_W-1:0] edgeCode;
    logic              capHit;
    logic              matchHit;
    logic [CNT_W-1:0]  chReg;
    logic              flagBit;
    logic              pulseBit;

    assign edgeCode = dpCtl.edgeSel[g*EDGE_W +: EDGE_W];
    assign capHit   = !dpCtl.modeSel[g] &&
                      ((edgeCode[0] && riseHit[g]) || (edgeCode[1] && fallHit[g]));
    assign matchHit = dpCtl.modeSel[g] && dpCtl.tmrEn && (cntNext == chReg);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chReg    <= '0;
        flagBit  <= 1'b0;
        pulseBit <= 1'b0;
      end else begin
        if (capHit)                                     chReg <= cntQ;
        else if (dpCtl.chanWr[g] && dpCtl.modeSel[g])   chReg <= dpCtl.wrData;
        if (capHit || matchHit)       flagBit <= 1'b1;
        else if (dpCtl.flagClr[g])    flagBit <= 1'b0;
        pulseBit <= matchHit;
      end
    end

    assign chanVals[g*CNT_W +: CNT_W] = chReg;
    assign chanFlags[g]               = flagBit;
    assign matchPulse[g]              = pulseBit;
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [CH_NUM-1:0] capIn,
  output logic [CH_NUM-1:0] matchPulse,
  output logic [CH_NUM-1:0] chanFlag,
  output logic              ovfFlag
);
  dpCtrl_t                 dpCtl;
  logic [CNT_W-1:0]        cntVal;
  logic [CH_NUM*CNT_W-1:0] chanVals;

  capcmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .cntVal    (cntVal),
    .chanVals  (chanVals),
    .chanFlags (chanFlag),
    .ovfFlag   (ovfFlag),
    .dpCtl     (dpCtl)
  );

  capcmp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .capIn      (capIn),
    .dpCtl      (dpCtl),
    .cntVal     (cntVal),
    .chanVals   (chanVals),
    .chanFlags  (chanFlag),
    .ovfFlag    (ovfFlag),
    .matchPulse (matchPulse)
  );
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk
  import capcmp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input dpCtrl_t           dpCtl,
  input logic [CNT_W-1:0]  cntVal,
  input logic              ovfFlag,
  input logic [CH_NUM-1:0] chanFlag,
  input logic [CH_NUM-1:0] matchPulse
);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.tmrEn |=> (cntVal == CNT_W'($past(cntVal) + CNT_W'(1))));

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.tmrEn |=> $stable(cntVal));

  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.tmrEn && (cntVal == '1)) |=> ovfFlag);

  assert_ovf_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !dpCtl.tmrEn && !dpCtl.accEn) |=> ovfFlag);

  assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((matchPulse & ~chanFlag) == '0));

  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.tmrEn && !dpCtl.accEn) |=> ((chanFlag & $past(chanFlag)) == $past(chanFlag)));
endmodule

bind capcmp_timer capcmp_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dpCtl      (dpCtl),
  .cntVal     (cntVal),
  .ovfFlag    (ovfFlag),
  .chanFlag   (chanFlag),
  .matchPulse (matchPulse)
);

// File: tb/sim_capcmp_timer.sv
`timescale 1ns/1ps
module sim_capcmp_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic       busRe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] capIn = '0;
  logic [7:0] matchPulse;
  logic [7:0] chanFlag;
  logic       ovfFlag;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  capcmp_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .capIn(capIn),
    .matchPulse(matchPulse), .chanFlag(chanFlag), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    logic [7:0] h, l;
    rd(a, h);
    rd(a + 5'd1, l);
    d = {h, l};
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    wr(a, d[15:8]);
    wr(a + 5'd1, d[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, v2, c, h, h2;
    logic [7:0]  b;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R8, R9, R1, R2)
    chk("R2 ovf reset", ovfFlag, 0);
    chk("R7 flags reset", chanFlag, 0);
    chk("R6 pulse reset", matchPulse, 0);
    rd16(5'h06, v); chk("R1 counter reset", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd16(5'(16 + 2*i), v); chk("R8 R9 channel reset", v, 0);
    end

    // R1 run and hold
    wr(5'h00, 8'h01);
    repeat (9) @(negedge clk);
    wr(5'h00, 8'h00);
    rd16(5'h06, v); chk("R1 counted", v, 10);
    repeat (5) @(negedge clk);
    rd16(5'h06, v); chk("R1 hold", v, 10);

    // R10 coherent reads of running counter
    wr(5'h00, 8'h01);
    rd16(5'h06, v);
    rd16(5'h06, v2);
    wr(5'h00, 8'h00);
    chk("R10 first snapshot", v, 10);
    chk("R10 snapshot distance", 32'(v2 - v), 2);

    // R4 R6 compare sweep
    wr(5'h01, 8'hFF);
    rd16(5'h06, c);
    for (int i = 0; i < 8; i++) wr16(5'(16 + 2*i), 16'(c + 4 + i));
    for (int i = 0; i < 8; i++) begin
      rd16(5'(16 + 2*i), v); chk("R8 compare write", v, 32'(16'(c + 4 + i)));
    end
    wr(5'h00, 8'h01);
    for (int s = 1; s <= 14; s++) begin
      logic [7:0] ep, ef;
      @(negedge clk);
      ep = (s >= 4 && s <= 11) ? 8'(1 << (s - 4)) : 8'h00;
      ef = '0;
      for (int i = 0; i < 8; i++) if (4 + i <= s) ef[i] = 1'b1;
      chk("R6 match pulse", matchPulse, ep);
      chk("R6 match flag", chanFlag, ef);
    end
    wr(5'h00, 8'h00);

    // R7 gated clear
    wr(5'h04, 8'hFF);
    chk("R7 clear ignored without enable", chanFlag, 8'hFF);
    wr(5'h00, 8'h02);
    wr(5'h04, 8'h0F);
    chk("R7 partial clear", chanFlag, 8'hF0);
    rd(5'h04, b); chk("R7 flag read", b, 8'hF0);
    wr(5'h04, 8'hF0);
    chk("R7 full clear", chanFlag, 0);

    // R8 capture mode ignores writes
    wr(5'h01, 8'h00);
    wr16(5'h16, 16'h1234);
    rd16(5'h16, v); chk("R8 capture write ignored", v, 32'(16'(c + 7)));

    // R5 edge select sweep: channel i uses code i%4
    wr(5'h02, 8'hE4);
    wr(5'h03, 8'hE4);
    rd16(5'h06, h);
    capIn = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R5 sync latency", chanFlag, 0);
    @(negedge clk);
    chk("R5 rising flags", chanFlag, 8'hAA);
    for (int i = 0; i < 8; i++) begin
      rd16(5'(16 + 2*i), v);
      chk("R5 rising capture", v, (i % 2 == 1) ? 32'(h) : 32'(16'(c + 4 + i)));
    end
    wr(5'h04, 8'hFF);
    wr(5'h00, 8'h03);
    repeat (3) @(negedge clk);
    wr(5'h00, 8'h02);
    rd16(5'h06, h2); chk("R1 counted again", h2, 32'(16'(h + 4)));
    capIn = 8'h00;
    repeat (3) @(negedge clk);
    chk("R5 falling flags", chanFlag, 8'hCC);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      if ((i % 4) >= 2) e = h2;
      else if (i % 2 == 1) e = h;
      else e = 16'(c + 4 + i);
      rd16(5'(16 + 2*i), v); chk("R5 falling capture", v, 32'(e));
    end

    // R11 high byte buffering, R10 latch
    wr(5'h01, 8'hFF);
    wr(5'h1A, 8'hAB);
    rd16(5'h1A, v); chk("R11 high write buffered", v, 32'(h));
    wr(5'h1B, 8'hCD);
    rd16(5'h1A, v); chk("R11 low write commits", v, 32'h0000ABCD);
    rd(5'h1A, b);
    wr16(5'h1A, 16'h1122);
    rd(5'h1B, b); chk("R10 low read from latch", b, 8'hCD);
    rd16(5'h1A, v); chk("R11 second commit", v, 32'h00001122);

    // R2 R3 overflow
    rd16(5'h06, c);
    wr(5'h00, 8'h01);
    k = 65536 - int'(c);
    repeat (k - 1) @(negedge clk);
    chk("R2 ovf before wrap", ovfFlag, 0);
    @(negedge clk);
    chk("R2 ovf on wrap", ovfFlag, 1);
    wr(5'h00, 8'h00);
    rd(5'h05, b); chk("R2 ovf read", b, 8'h80);
    wr(5'h05, 8'h80);
    chk("R3 clear ignored without enable", ovfFlag, 1);
    wr(5'h00, 8'h02);
    wr(5'h05, 8'h7F);
    chk("R3 bit7 clear needed", ovfFlag, 1);
    wr(5'h05, 8'h80);
    chk("R3 clear with accumulate enable", ovfFlag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule